// File: doc/BRIEF.md
# Line Test Pattern Generator

This block produces the serial transmit bit stream of a T1/E1 line interface. When maintenance testing is active, it replaces user data with a fixed or pseudo-random test pattern. A two-bit pattern select, a clock-source flag, a line-mode bit (T1/J1 or E1) and an invert control choose what goes out on each bit slot:

- user data passed through;
- a constant level (all zeros or all ones);
- a pseudo-random sequence whose length depends on the line mode.

Everything runs in one clock domain. A bit-enable strobe marks each bit slot. On every strobe the output register takes the selected bit and both sequence generators step once. In E1 mode the sequence is a 2^15−1 maximal-length pattern. In T1/J1 mode it is a 2^20−1 pattern with zero-run suppression, which keeps the line from going quiet for long stretches.

Top module: `line_test_pattern_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first bit strobe, `tx_data_out` is 0. Reset loads both generators with the all-ones seed.
- R2: With `pat_sel` 00 or 11 and `alt_clk_sel` 0, each strobe copies `tx_data_in` to `tx_data_out`.
- R3: With `pat_sel` 00 or 11 and `alt_clk_sel` 1, each strobe drives 0, whatever `tx_data_in` is.
- R4: With `pat_sel` 01, each strobe drives 1, whatever `tx_data_in` is.
- R5: With `pat_sel` 10 and `t1_mode` 0, the output follows a 15-bit register `s` with seed all ones. The bit sent is `s[14]` (most significant bit first). The register then shifts left and takes `s[14]^s[13]` into `s[0]` (polynomial x^15+x^14+1). The sequence repeats every 32767 bits.
- R6: With `pat_sel` 10 and `t1_mode` 1, the output follows a 20-bit register `s` with seed all ones. The bit sent is `s[19]`, forced to 1 when `s[18:5]` are all zero. The register then shifts left and takes `s[19]^s[16]` into `s[0]` (polynomial x^20+x^17+1).
- R7: In the T1/J1 pseudo-random pattern, no more than 14 consecutive zeros are sent.
- R8: With `prbs_inv` 1, the pseudo-random pattern is sent complemented. `prbs_inv` has no effect on codes 00, 01 and 11.
- R9: Without a strobe, `tx_data_out` holds its value and the generators do not advance. With a strobe, the generators advance whatever the select code is.
- R10: Any change of `t1_mode` reloads both generators with the all-ones seed on the next clock edge. The reload overrides a strobe in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit-slot strobe |
| tx_data_in | input | 1 | User transmit data |
| pat_sel | input | 2 | Pattern select: 00/11 user or zeros, 01 ones, 10 pseudo-random |
| alt_clk_sel | input | 1 | Clock-source flag; turns code 00/11 into all zeros |
| t1_mode | input | 1 | 1: T1/J1 20-bit sequence, 0: E1 15-bit sequence |
| prbs_inv | input | 1 | Complement the pseudo-random pattern |
| tx_data_out | output | 1 | Serial transmit data |

## Verification
The hardest condition to reach from the ports is the zero-run limit of the T1/J1 pattern. It only shows once the 20-bit register has walked far enough from its seed to hold long runs of zero bits. The stimulus therefore streams twenty thousand consecutive strobes in T1/J1 mode. It compares every bit with a model built from the stated polynomial and records the longest zero run. The E1 period is shown the same way: a full 32767-bit lap is streamed, and the next 64 bits must equal the first 64.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;
  typedef enum logic [1:0] {
    PAT_USER = 2'b00,
    PAT_ONES = 2'b01,
    PAT_PRBS = 2'b10,
    PAT_ALT  = 2'b11
  } pat_sel_e;

  localparam int unsigned E1_LEN   = 15;
  localparam int unsigned E1_TAP   = 14;
  localparam int unsigned T1_LEN   = 20;
  localparam int unsigned T1_TAP   = 17;
  localparam int unsigned T1_ZRUN  = 14;
endpackage

// File: rtl/ltpg_rst_sync.sv
module ltpg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ltpg_lfsr.sv
module ltpg_lfsr #(
  parameter int unsigned WIDTH = 15,
  parameter int unsigned TAP   = 14,
  parameter int unsigned ZRUN  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic reload,
  output logic bit_o
);
  localparam logic [WIDTH-1:0] SEED = {WIDTH{1'b1}};

  logic [WIDTH-1:0] state_q, state_d;
  logic             fb;

  assign fb = state_q[WIDTH-1] ^ state_q[TAP-1];

  always_comb begin
    state_d = state_q;
    if (reload)    state_d = SEED;
    else if (step) state_d = {state_q[WIDTH-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  generate
    if (ZRUN > 0) begin : g_zsup
      logic window_zero;
      assign window_zero = ~|state_q[WIDTH-2 -: ZRUN];
      assign bit_o       = state_q[WIDTH-1] | window_zero;
    end else begin : g_plain
      assign bit_o = state_q[WIDTH-1];
    end
  endgenerate
endmodule

// File: rtl/ltpg_out_mux.sv
module ltpg_out_mux
  import ltpg_pkg::*;
(
  input  logic [1:0] pat_sel,
  input  logic       alt_clk_sel,
  input  logic       t1_mode,
  input  logic       prbs_inv,
  input  logic       user_bit,
  input  logic       e1_bit,
  input  logic       t1_bit,
  output logic       bit_o
);
  logic seq_bit;

  assign seq_bit = (t1_mode ? t1_bit : e1_bit) ^ prbs_inv;

  always_comb begin
    unique case (pat_sel_e'(pat_sel))
      PAT_ONES: bit_o = 1'b1;
      PAT_PRBS: bit_o = seq_bit;
      default:  bit_o = alt_clk_sel ? 1'b0 : user_bit;
    endcase
  end
endmodule

// File: rtl/line_test_pattern_gen.sv
module line_test_pattern_gen
  import ltpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       tx_data_in,
  input  logic [1:0] pat_sel,
  input  logic       alt_clk_sel,
  input  logic       t1_mode,
  input  logic       prbs_inv,
  output logic       tx_data_out
);
  logic rst_sync_n;
  logic mode_q;
  logic reload;
  logic e1_bit, t1_bit, sel_bit;
  logic out_q, out_d;

  ltpg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign reload = (t1_mode != mode_q);

  ltpg_lfsr #(.WIDTH(E1_LEN), .TAP(E1_TAP), .ZRUN(0)) u_e1_gen (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step   (bit_en),
    .reload (reload),
    .bit_o  (e1_bit)
  );

  ltpg_lfsr #(.WIDTH(T1_LEN), .TAP(T1_TAP), .ZRUN(T1_ZRUN)) u_t1_gen (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step   (bit_en),
    .reload (reload),
    .bit_o  (t1_bit)
  );

  ltpg_out_mux u_mux (
    .pat_sel     (pat_sel),
    .alt_clk_sel (alt_clk_sel),
    .t1_mode     (t1_mode),
    .prbs_inv    (prbs_inv),
    .user_bit    (tx_data_in),
    .e1_bit      (e1_bit),
    .t1_bit      (t1_bit),
    .bit_o       (sel_bit)
  );

  always_comb begin
    out_d = out_q;
    if (bit_en) out_d = sel_bit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      mode_q <= t1_mode;
    end
  end

  assign tx_data_out = out_q;
endmodule

// File: rtl/ltpg_checker.sv
module ltpg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       tx_data_in,
  input logic [1:0] pat_sel,
  input logic       alt_clk_sel,
  input logic       t1_mode,
  input logic       prbs_inv,
  input logic       tx_data_out
);
  localparam int unsigned MAX_ZRUN = 14;

  logic       qrss_mode;
  logic       armed_q;
  logic [4:0] zrun_q;

  assign qrss_mode = (pat_sel == 2'b10) && t1_mode && !prbs_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      zrun_q  <= '0;
    end else begin
      armed_q <= bit_en && qrss_mode;
      if (armed_q)
        zrun_q <= tx_data_out ? 5'd0 : zrun_q + {4'd0, (zrun_q != 5'd31)};
      else if (bit_en && !qrss_mode)
        zrun_q <= '0;
    end
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (pat_sel == 2'b00 || pat_sel == 2'b11) && !alt_clk_sel)
      |=> (tx_data_out == $past(tx_data_in)));

  p_zeros_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (pat_sel == 2'b00 || pat_sel == 2'b11) && alt_clk_sel)
      |=> (tx_data_out == 1'b0));

  p_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && pat_sel == 2'b01) |=> (tx_data_out == 1'b1));

  p_zero_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zrun_q <= 5'(MAX_ZRUN));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_data_out));
endmodule

bind line_test_pattern_gen ltpg_checker u_ltpg_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bit_en      (bit_en),
  .tx_data_in  (tx_data_in),
  .pat_sel     (pat_sel),
  .alt_clk_sel (alt_clk_sel),
  .t1_mode     (t1_mode),
  .prbs_inv    (prbs_inv),
  .tx_data_out (tx_data_out)
);

// File: tb/line_test_pattern_gen_bench.sv
module line_test_pattern_gen_bench;
  logic       clk;
  logic       rst_n;
  logic       bit_en;
  logic       tx_data_in;
  logic [1:0] pat_sel;
  logic       alt_clk_sel;
  logic       t1_mode;
  logic       prbs_inv;
  logic       tx_data_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [14:0] m15;
  logic [19:0] m20;

  line_test_pattern_gen u_line_test_pattern_gen (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_data_in(tx_data_in),
    .pat_sel(pat_sel), .alt_clk_sel(alt_clk_sel), .t1_mode(t1_mode),
    .prbs_inv(prbs_inv), .tx_data_out(tx_data_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic one_bit(output logic b);
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    b = tx_data_out;
  endtask

  function automatic logic e1_next();
    logic b;
    b   = m15[14];
    m15 = {m15[13:0], m15[14] ^ m15[13]};
    return b;
  endfunction

  function automatic logic t1_next();
    logic b;
    b   = m20[19] | (m20[18:5] == 14'd0);
    m20 = {m20[18:0], m20[19] ^ m20[16]};
    return b;
  endfunction

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; t1_mode = mode;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    m15 = '1; m20 = '1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(tx_data_out == 1'b0, "R1 during reset", tx_data_out, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_data_out == 1'b0, "R1 after release", tx_data_out, 0);
  endtask

  task automatic t_pass();
    logic b;
    logic [7:0] pat = 8'b1011_0010;
    int bad = 0;
    alt_clk_sel = 1'b0; prbs_inv = 1'b1;
    foreach (pat[i]) begin
      pat_sel    = (i % 2 == 0) ? 2'b00 : 2'b11;
      tx_data_in = pat[i];
      one_bit(b);
      if (b !== pat[i]) bad++;
    end
    check(bad == 0, "R2 pass-through codes 00/11", bad, 0);
  endtask

  task automatic t_zeros();
    logic b;
    int bad = 0;
    alt_clk_sel = 1'b1; tx_data_in = 1'b1;
    for (int i = 0; i < 6; i++) begin
      pat_sel  = (i % 2 == 0) ? 2'b00 : 2'b11;
      prbs_inv = i[1];
      one_bit(b);
      if (b !== 1'b0) bad++;
    end
    check(bad == 0, "R3 zeros with clock flag", bad, 0);
    check(bad == 0, "R8 invert ignored for zeros", bad, 0);
  endtask

  task automatic t_ones();
    logic b;
    int bad = 0;
    pat_sel = 2'b01; tx_data_in = 1'b0;
    for (int i = 0; i < 6; i++) begin
      alt_clk_sel = i[0];
      prbs_inv    = i[1];
      one_bit(b);
      if (b !== 1'b1) bad++;
    end
    check(bad == 0, "R4 all ones", bad, 0);
  endtask

  task automatic t_e1();
    logic b;
    logic [63:0] head;
    int bad = 0, lap_bad = 0;
    alt_clk_sel = 1'b0; prbs_inv = 1'b0; pat_sel = 2'b10;
    do_reset(1'b0);
    for (int i = 0; i < 32767 + 64; i++) begin
      one_bit(b);
      if (b !== e1_next()) bad++;
      if (i < 64) head[i] = b;
      else if (i >= 32767 && b !== head[i-32767]) lap_bad++;
    end
    check(bad == 0, "R5 E1 sequence", bad, 0);
    check(lap_bad == 0, "R5 E1 period 32767", lap_bad, 0);
  endtask

  task automatic t_t1();
    logic b;
    int bad = 0, run = 0, max_run = 0;
    alt_clk_sel = 1'b0; prbs_inv = 1'b0; pat_sel = 2'b10;
    do_reset(1'b1);
    for (int i = 0; i < 20000; i++) begin
      one_bit(b);
      if (b !== t1_next()) bad++;
      if (b == 1'b0) run++; else run = 0;
      if (run > max_run) max_run = run;
    end
    check(bad == 0, "R6 T1 sequence", bad, 0);
    check(max_run <= 14, "R7 zero run limit", max_run, 14);
  endtask

  task automatic t_inv();
    logic b;
    int bad = 0;
    alt_clk_sel = 1'b0; prbs_inv = 1'b1; pat_sel = 2'b10;
    do_reset(1'b0);
    for (int i = 0; i < 200; i++) begin
      one_bit(b);
      if (b !== ~e1_next()) bad++;
    end
    check(bad == 0, "R8 inverted E1", bad, 0);
    prbs_inv = 1'b0;
  endtask

  task automatic t_hold();
    logic b, held;
    int bad = 0, moved = 0;
    pat_sel = 2'b10; prbs_inv = 1'b0;
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) begin
      one_bit(b);
      if (b !== e1_next()) bad++;
    end
    held = tx_data_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk) tx_data_in = i[0];
      if (tx_data_out !== held) moved++;
    end
    check(moved == 0, "R9 output holds without strobe", moved, 0);
    for (int i = 0; i < 10; i++) begin
      one_bit(b);
      if (b !== e1_next()) bad++;
    end
    check(bad == 0, "R9 no advance without strobe", bad, 0);
    pat_sel = 2'b01;
    for (int i = 0; i < 7; i++) begin
      one_bit(b);
      void'(e1_next());
    end
    pat_sel = 2'b10;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      one_bit(b);
      if (b !== e1_next()) bad++;
    end
    check(bad == 0, "R9 advance under other codes", bad, 0);
  endtask

  task automatic t_reload();
    logic b;
    int bad = 0;
    pat_sel = 2'b10; prbs_inv = 1'b0;
    do_reset(1'b0);
    for (int i = 0; i < 37; i++) one_bit(b);
    @(negedge clk) t1_mode = 1'b1;
    repeat (3) @(negedge clk);
    t1_mode = 1'b0;
    repeat (3) @(negedge clk);
    m15 = '1;
    for (int i = 0; i < 40; i++) begin
      one_bit(b);
      if (b !== e1_next()) bad++;
    end
    check(bad == 0, "R10 reseed on mode change", bad, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; tx_data_in = 1'b0; pat_sel = 2'b00;
    alt_clk_sel = 1'b0; t1_mode = 1'b0; prbs_inv = 1'b0;
    m15 = '1; m20 = '1;
    t_reset();
    t_pass();
    t_zeros();
    t_ones();
    t_e1();
    t_t1();
    t_inv();
    t_hold();
    t_reload();
    finish_run();
  end
endmodule